// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

The block is a down-counting watchdog with a small synchronous register port. Software programs a reload value and then sets the run bit in the control register. From then on the counter runs down to zero, reloads itself and keeps going. The first time it reaches zero it raises a pending interrupt. If software has not acknowledged that interrupt by the time the counter reaches zero again, the block emits a one-cycle system reset pulse and then puts all of its own state back to power-on values.

The run bit locks itself. Once it has been set, the control register no longer accepts writes, so a runaway program cannot stop the watchdog. Only a hardware reset, or the watchdog's own reset pulse, releases it. Each accepted register write opens a short busy window, which models a slower watchdog clock domain. A status bit shows this window, and any write that arrives during it is discarded.

Top module: `wdog_twostage`

## Requirements
- R1: After a hardware reset, the control word (offset 0x08) reads 0x80000000, the reload register reads 0xFFFFFFFF, the count and interrupt status read 0, and `irq_o` and `wdt_rst_o` are low.
- R2: The register map uses byte offsets with 32-bit data, and `rdata` is valid in the cycle after `rd_en`. Offset 0x00 is the read/write reload value. Offset 0x04 is the read-only current count. Offset 0x08 is the control word. Offset 0x0C is the write-only interrupt acknowledge, which reads 0. Offset 0x10 is the read-only interrupt status in bit 0. Writes to the read-only offsets change nothing.
- R3: An accepted write drives control bit 31 to 0 for exactly 4 cycles. Any write that arrives while bit 31 is 0 is discarded.
- R4: Control bit 2 (interrupt type) is stored and reads back while the block is unlocked. Control bit 1 and bits 30..3 always read 0.
- R5: Writing 1 to control bit 0 starts the watchdog. While bit 0 is 1, every write to the control word is ignored, including writes to bit 2. Bit 0 is cleared only by a hardware reset or by the watchdog's own reset pulse.
- R6: The start write loads the count from the reload value L. While the watchdog runs, the count decreases by one per cycle. In the cycle after the count is 0, the count reloads to L and an expiry occurs. An expiry therefore falls L+1 cycles after the start write and every L+1 cycles after that.
- R7: An expiry with no interrupt pending sets the status bit. `irq_o` equals the status bit gated by control bit 0.
- R8: Any write to offset 0x0C clears the pending status bit and reloads the count from the reload value.
- R9: An expiry while the status bit is still set produces a pulse on `wdt_rst_o` that lasts exactly one cycle. At the same edge, all registers return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Watchdog interrupt (first expiry) |
| wdt_rst_o | output | 1 | One-cycle system reset request (second expiry) |

## Verification
The bench counts cycles from the start write and looks for the interrupt exactly L+1 cycles later and the reset pulse exactly 2L+2 cycles later. A counter that reloads one cycle too early or too late fails both checks. It writes to the control word while the block is locked, so a design that let software clear the run bit, or change the type bit, shows the wrong control word. It issues back-to-back writes, which catches a busy window that is missing or too short, because the second reload value then sticks. It also checks that an acknowledged interrupt never turns into a reset, and that the whole block reads as freshly reset after its own reset pulse, with the lock released.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned BUS_W = 32;

  localparam int unsigned OFS_LOAD  = 'h00;
  localparam int unsigned OFS_VALUE = 'h04;
  localparam int unsigned OFS_CTL   = 'h08;
  localparam int unsigned OFS_ICLR  = 'h0C;
  localparam int unsigned OFS_RIS   = 'h10;

  localparam int unsigned CTL_WC_BIT   = 31;
  localparam int unsigned CTL_TYPE_BIT = 2;
  localparam int unsigned CTL_RUN_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_VALUE,
    SEL_CTL,
    SEL_ICLR,
    SEL_RIS
  } reg_sel_e;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned BUSY_CYC = 4,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              ris,
  output logic [BUS_W-1:0]  rdata,
  output logic [CNT_W-1:0]  load_q,
  output logic              run_q,
  output logic              start_o,
  output logic              iclr_o
);

  localparam int unsigned BW = $clog2(BUSY_CYC + 1);

  logic [BW-1:0]    busy_q;
  logic             type_q;
  logic             wr_ok;
  logic             wc;
  reg_sel_e         sel;
  logic [BUS_W-1:0] ctl_word;
  logic [BUS_W-1:0] rd_mux;

  always_comb begin
    if (addr == ADDR_W'(OFS_LOAD))       sel = SEL_LOAD;
    else if (addr == ADDR_W'(OFS_VALUE)) sel = SEL_VALUE;
    else if (addr == ADDR_W'(OFS_CTL))   sel = SEL_CTL;
    else if (addr == ADDR_W'(OFS_ICLR))  sel = SEL_ICLR;
    else if (addr == ADDR_W'(OFS_RIS))   sel = SEL_RIS;
    else                                 sel = SEL_NONE;
  end

  assign wc      = (busy_q == '0);
  assign wr_ok   = wr_en && wc;
  assign start_o = wr_ok && (sel == SEL_CTL) && !run_q && wdata[CTL_RUN_BIT];
  assign iclr_o  = wr_ok && (sel == SEL_ICLR);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_q <= '0;
      load_q <= LOAD_RST;
      run_q  <= 1'b0;
      type_q <= 1'b0;
    end else begin
      if (wr_ok)
        busy_q <= BW'(BUSY_CYC);
      else if (busy_q != '0)
        busy_q <= busy_q - 1'b1;
      if (wr_ok && sel == SEL_LOAD)
        load_q <= wdata[CNT_W-1:0];
      if (wr_ok && sel == SEL_CTL && !run_q) begin
        run_q  <= wdata[CTL_RUN_BIT];
        type_q <= wdata[CTL_TYPE_BIT];
      end
    end
  end

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_WC_BIT]   = wc;
    ctl_word[CTL_TYPE_BIT] = type_q;
    ctl_word[CTL_RUN_BIT]  = run_q;
  end

  always_comb begin
    case (sel)
      SEL_LOAD:  rd_mux = BUS_W'(load_q);
      SEL_VALUE: rd_mux = BUS_W'(count);
      SEL_CTL:   rd_mux = ctl_word;
      SEL_RIS:   rd_mux = BUS_W'(ris);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (run_q && !clr) |=> run_q); // R5

  AST_WR_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_q != '0 && !clr) |=> ($stable(load_q) && $stable(run_q) && $stable(type_q))); // R3

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !clr) |=> (busy_q != '0)); // R3

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             start,
  input  logic             reload,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);

  logic at_zero;

  assign at_zero = (count_q == '0);
  assign expire  = run && at_zero;

  always_ff @(posedge clk) begin
    if (rst || clr)
      count_q <= '0;
    else if (start || reload)
      count_q <= load;
    else if (run)
      count_q <= at_zero ? load : count_q - 1'b1;
  end

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (expire && !clr && !reload && !start) |=> (count_q == $past(load))); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !at_zero && !clr && !reload && !start) |=> (count_q == $past(count_q) - 1'b1)); // R6

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic iclr,
  input  logic run,
  output logic ris_q,
  output logic fire,
  output logic irq_o,
  output logic rst_o
);

  assign fire  = expire && ris_q && !iclr;
  assign irq_o = ris_q && run;

  always_ff @(posedge clk) begin
    if (rst)
      ris_q <= 1'b0;
    else if (iclr || fire)
      ris_q <= 1'b0;
    else if (expire)
      ris_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rst_o <= 1'b0;
    else
      rst_o <= fire;
  end

  AST_RIS_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (expire && !ris_q && !iclr) |=> ris_q); // R7

  AST_ICLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    iclr |=> !ris_q); // R8

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rst_o |=> !rst_o); // R9

  AST_RST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> ($past(ris_q) && !ris_q)); // R9

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned BUSY_CYC = 4,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             start;
  logic             iclr;
  logic             expire;
  logic             ris_q;
  logic             fire;

  wdog_regif #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .BUSY_CYC(BUSY_CYC),
    .LOAD_RST(LOAD_RST)
  ) u_regif (
    .clk    (clk),
    .rst    (rst),
    .clr    (fire),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .count  (count_q),
    .ris    (ris_q),
    .rdata  (rdata),
    .load_q (load_q),
    .run_q  (run_q),
    .start_o(start),
    .iclr_o (iclr)
  );

  wdog_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst    (rst),
    .clr    (fire),
    .run    (run_q),
    .start  (start),
    .reload (iclr),
    .load   (load_q),
    .count_q(count_q),
    .expire (expire)
  );

  wdog_stage u_stage (
    .clk   (clk),
    .rst   (rst),
    .expire(expire),
    .iclr  (iclr),
    .run   (run_q),
    .ris_q (ris_q),
    .fire  (fire),
    .irq_o (irq_o),
    .rst_o (wdt_rst_o)
  );

  AST_RST_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> (!run_q && !irq_o)); // R9

endmodule

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic        rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;
  logic        wdt_rst_o;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] CTL_RST = 32'h8000_0000;

  always #2 clk = ~clk;

  wdog_twostage u_wdog_twostage (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq_o    (irq_o),
    .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr  = a;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 wdt_rst_o", 32'(wdt_rst_o), 0);
    rd(5'h08, d); chk("R1 ctl", d, CTL_RST);
    rd(5'h00, d); chk("R1 load", d, 32'hFFFF_FFFF);
    rd(5'h04, d); chk("R1 value", d, 0);
    rd(5'h10, d); chk("R1 ris", d, 0);
    rd(5'h0C, d); chk("R2 iclr reads 0", d, 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(5'h00, 32'd5);
    wr(5'h00, 32'd7);
    rd(5'h08, d); chk("R3 busy flag low", d, 32'h0000_0000);
    settle();
    rd(5'h08, d); chk("R3 busy flag back", d, CTL_RST);
    rd(5'h00, d); chk("R3 second write dropped", d, 32'd5);
    wr(5'h04, 32'h55); settle();
    rd(5'h04, d); chk("R2 value read-only", d, 0);
    wr(5'h10, 32'h1); settle();
    rd(5'h10, d); chk("R2 ris read-only", d, 0);
  endtask

  task automatic t_ctl_bits();
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFFE); settle();
    rd(5'h08, d); chk("R4 type bit and reserved", d, 32'h8000_0004);
    wr(5'h08, 32'h0); settle();
    rd(5'h08, d); chk("R4 type bit cleared", d, CTL_RST);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    logic [31:0] v1;
    wr(5'h00, 32'd1000); settle();
    wr(5'h08, 32'h1); settle();
    wr(5'h08, 32'h4); settle();
    rd(5'h08, d); chk("R5 lock ignores write", d, 32'h8000_0001);
    rd(5'h04, v1);
    rd(5'h04, d); chk("R6 count decrements", d, v1 - 1);
    hard_reset();
    rd(5'h08, d); chk("R5 hard reset unlocks", d, CTL_RST);
  endtask

  task automatic t_two_stage();
    logic [31:0] d;
    int L = 20;
    wr(5'h00, 32'(L)); settle();
    wr(5'h08, 32'h1);
    rd(5'h04, d); chk("R6 count loaded at start", d, 32'(L));
    repeat (L - 1) @(negedge clk);
    chk("R7 no irq before expiry", 32'(irq_o), 0);
    @(negedge clk);
    chk("R7 irq at first expiry", 32'(irq_o), 1);
    repeat (L) @(negedge clk);
    chk("R9 no reset early", 32'(wdt_rst_o), 0);
    @(negedge clk);
    chk("R9 reset pulse", 32'(wdt_rst_o), 1);
    chk("R9 irq dropped", 32'(irq_o), 0);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(wdt_rst_o), 0);
    rd(5'h08, d); chk("R9 ctl back to reset", d, CTL_RST);
    rd(5'h00, d); chk("R9 load back to reset", d, 32'hFFFF_FFFF);
    rd(5'h10, d); chk("R9 ris back to reset", d, 0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    int L = 16;
    int seen_rst = 0;
    wr(5'h00, 32'(L)); settle();
    wr(5'h08, 32'h1);
    repeat (L + 1) @(negedge clk);
    chk("R7 irq before ack", 32'(irq_o), 1);
    wr(5'h0C, 32'hDEAD);
    chk("R8 irq cleared", 32'(irq_o), 0);
    rd(5'h04, d); chk("R8 counter reloaded", d, 32'(L));
    rd(5'h10, d); chk("R8 ris cleared", d, 0);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      if (wdt_rst_o) seen_rst = 1;
    end
    chk("R8 no reset after ack", 32'(seen_rst), 0);
    chk("R7 irq raised again", 32'(irq_o), 1);
    hard_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst   = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    addr  = '0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_busy();
    hard_reset();
    t_ctl_bits();
    hard_reset();
    t_lock();
    t_two_stage();
    hard_reset();
    t_ack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule